// File: doc/BRIEF.md
# Heightmap Framebuffer Writer with 2x Pixel Scaling

This block copies a finished square-grid heightmap into a pixel framebuffer once the terrain solver signals completion. It reads each map point from a memory with one cycle of read latency and turns the 8-bit height into an 8-bit pixel colour. Each map point is drawn as a 2x2 block of identical pixels, so the picture is twice the map size in both directions.

Drawing goes through the map row by row. A map row is drawn twice, once for each of its two pixel rows, and the map is re-read for the second pass. Within a pixel row, each map point writes its left pixel and then its right pixel. All coordinates are shifted by a fixed origin offset so the image lands inside the visible area, in the left half of the screen. After the final pixel, the block raises a completion flag and stays idle until it is reset.

Top module: `hm_upscale_writer`

## Requirements
- R1: While reset is asserted and right after it, the framebuffer write strobe is low and the completion flag is low.
- R2: No pixel is written until the solver-done input has been sampled high at a rising clock edge. A one-cycle pulse of that input starts a full drawing. Dropping the input after that has no effect on the drawing.
- R3: The first pixel write appears on the second rising edge after the edge that samples solver-done high. From then on there is exactly one write per clock cycle, with no gaps, until the drawing ends.
- R4: Write order has three nested levels. The outer level is map rows, from row 0 upward. For each map row, pixel sub-row 0 is drawn across all columns, then pixel sub-row 1. For each column, sub-pixel 0 (left) is written before sub-pixel 1 (right).
- R5: The write for map point (row, col) at sub-pixel (sx, sy) has x = X_OFF + 2*col + sx and y = Y_OFF + 2*row + sy.
- R6: The colour of each write equals the 8-bit value stored at map address row*MAP_W + col. The map memory returns data one cycle after the address is presented.
- R7: One drawing produces exactly 4*MAP_W*MAP_H pixel writes.
- R8: The completion flag rises on the cycle after the last pixel write. It then stays high, and no further writes occur until reset, even if solver-done is high.
- R9: A reset during a drawing stops the writes at once and clears the completion flag. The next drawing starts again from map point (0,0).
- R10: Every written x coordinate lies in the range X_OFF up to, but not including, SCREEN_W/2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| solve_done | input | 1 | Solver has finished the heightmap |
| map_rd_addr | output | ADDR_W | Heightmap read address, row*MAP_W + col |
| map_rd_data | input | PIX_W | Height read from the map, valid one cycle after the address |
| fb_x | output | XW | Pixel x coordinate |
| fb_y | output | YW | Pixel y coordinate |
| fb_color | output | PIX_W | Pixel colour |
| fb_we | output | 1 | Pixel write strobe |
| draw_done | output | 1 | Drawing complete, held until reset |

## Verification
Some properties are checked on every cycle:
- No write happens before solver-done has been seen.
- Every x coordinate stays inside the left half of the screen.
- Each left sub-pixel is followed immediately by its right neighbour, with the same y and the same colour.
- The completion flag only rises after a write, then stays high, and no writes occur while it is high.

Other behaviour can only be shown by the bench scenarios, which compare every write against an order and colour computed independently:
- the exact start latency;
- the full traversal order and its re-read of each map row;
- the alignment of the colour with the one-cycle memory latency;
- the total write count;
- abort and restart through reset.

// File: rtl/hm_upscale_writer.sv
module hm_upscale_writer #(
  parameter int MAP_W    = 65,
  parameter int MAP_H    = 65,
  parameter int PIX_W    = 8,
  parameter int SCREEN_W = 640,
  parameter int SCREEN_H = 480,
  parameter int X_OFF    = 8,
  parameter int Y_OFF    = 8,
  localparam int ADDR_W  = $clog2(MAP_W * MAP_H),
  localparam int XW      = $clog2(SCREEN_W),
  localparam int YW      = $clog2(SCREEN_H)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              solve_done,
  output logic [ADDR_W-1:0] map_rd_addr,
  input  logic [PIX_W-1:0]  map_rd_data,
  output logic [XW-1:0]     fb_x,
  output logic [YW-1:0]     fb_y,
  output logic [PIX_W-1:0]  fb_color,
  output logic              fb_we,
  output logic              draw_done
);
  localparam int CW = $clog2(MAP_W);
  localparam int RW = $clog2(MAP_H);

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_HALT} st_t;

  st_t               state;
  logic [CW-1:0]     col;
  logic [RW-1:0]     row;
  logic              sx, sy;
  logic [ADDR_W-1:0] row_base;
  logic              we_q, last_q, done_q;
  logic [XW-1:0]     x_q;
  logic [YW-1:0]     y_q;

  wire issue   = (state == ST_RUN);
  wire col_end = (col == CW'(MAP_W - 1));
  wire row_end = (row == RW'(MAP_H - 1));
  wire last_pt = row_end & sy & col_end & sx;

  // traversal counters: sub-pixel x fastest, then column, then sub-row, then row
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      col      <= '0;
      row      <= '0;
      sx       <= 1'b0;
      sy       <= 1'b0;
      row_base <= '0;
    end else begin
      case (state)
        ST_IDLE: if (solve_done) state <= ST_RUN;
        ST_RUN: begin
          sx <= ~sx;
          if (sx) begin
            if (col_end) begin
              col <= '0;
              if (sy) begin
                sy       <= 1'b0;
                row      <= row + 1'b1;
                row_base <= row_base + ADDR_W'(MAP_W);
              end else begin
                sy <= 1'b1;
              end
            end else begin
              col <= col + 1'b1;
            end
          end
          if (last_pt) state <= ST_HALT;
        end
        default: state <= ST_HALT;
      endcase
    end
  end

  // one-cycle stage matching the map read latency
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      we_q   <= 1'b0;
      last_q <= 1'b0;
      done_q <= 1'b0;
      x_q    <= '0;
      y_q    <= '0;
    end else begin
      we_q   <= issue;
      last_q <= issue & last_pt;
      done_q <= done_q | last_q;
      x_q    <= XW'(X_OFF) + XW'({col, sx});
      y_q    <= YW'(Y_OFF) + YW'({row, sy});
    end
  end

  assign map_rd_addr = row_base + ADDR_W'(col);
  assign fb_we       = we_q;
  assign fb_x        = x_q;
  assign fb_y        = y_q;
  assign fb_color    = map_rd_data;
  assign draw_done   = done_q;
endmodule

// File: rtl/hm_upscale_writer_chk.sv
module hm_upscale_writer_chk #(
  parameter int PIX_W    = 8,
  parameter int SCREEN_W = 640,
  parameter int X_OFF    = 8,
  parameter int XW       = 10,
  parameter int YW       = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             solve_done,
  input logic [XW-1:0]    fb_x,
  input logic [YW-1:0]    fb_y,
  input logic [PIX_W-1:0] fb_color,
  input logic             fb_we,
  input logic             draw_done
);
  logic seen_q;
  always_ff @(posedge clk) begin
    if (!rst_n) seen_q <= 1'b0;
    else if (solve_done) seen_q <= 1'b1;
  end

  wire left_sub = ((int'(fb_x) - X_OFF) % 2) == 0;

  AST_NO_EARLY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    fb_we |-> seen_q); // R2
  AST_X_LEFT_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    fb_we |-> (int'(fb_x) >= X_OFF && int'(fb_x) < SCREEN_W / 2)); // R10
  AST_PAIR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (fb_we && left_sub) |=> (fb_we && fb_x == $past(fb_x) + XW'(1) && $stable(fb_y) && $stable(fb_color))); // R5
  AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    draw_done |=> draw_done); // R8
  AST_QUIET_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    draw_done |-> !fb_we); // R8
  AST_DONE_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(draw_done) |-> $past(fb_we)); // R8
endmodule

bind hm_upscale_writer hm_upscale_writer_chk #(
  .PIX_W(PIX_W), .SCREEN_W(SCREEN_W), .X_OFF(X_OFF), .XW(XW), .YW(YW)
) chk_i (
  .clk(clk), .rst_n(rst_n), .solve_done(solve_done), .fb_x(fb_x), .fb_y(fb_y),
  .fb_color(fb_color), .fb_we(fb_we), .draw_done(draw_done)
);

// File: tb/hm_upscale_writer_tb_top.sv
module hm_upscale_writer_tb_top;
  localparam int MW = 5, MH = 3, SW = 64, SH = 48, XO = 3, YO = 2;
  localparam int AW = $clog2(MW * MH), XW = $clog2(SW), YW = $clog2(SH);

  logic clk = 1'b0, rst_n = 1'b0, solve_done = 1'b0;
  logic [AW-1:0] map_rd_addr;
  logic [7:0]    map_rd_data;
  logic [XW-1:0] fb_x;
  logic [YW-1:0] fb_y;
  logic [7:0]    fb_color;
  logic          fb_we, draw_done;
  logic [7:0]    mem [0:MW*MH-1];
  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  always_ff @(posedge clk) map_rd_data <= mem[map_rd_addr];

  hm_upscale_writer #(.MAP_W(MW), .MAP_H(MH), .PIX_W(8), .SCREEN_W(SW), .SCREEN_H(SH),
    .X_OFF(XO), .Y_OFF(YO)) dut_i (
    .clk(clk), .rst_n(rst_n), .solve_done(solve_done), .map_rd_addr(map_rd_addr),
    .map_rd_data(map_rd_data), .fb_x(fb_x), .fb_y(fb_y), .fb_color(fb_color),
    .fb_we(fb_we), .draw_done(draw_done));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic fill(input int seed);
    for (int a = 0; a < MW * MH; a++) mem[a] = 8'((a * 37 + seed * 11 + 5) & 255);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; solve_done = 1'b0;
    @(negedge clk);
    chk(fb_we == 1'b0, "R1 we in reset", fb_we, 0);
    chk(draw_done == 1'b0, "R1 done in reset", draw_done, 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk(fb_we == 1'b0, "R1 we after reset", fb_we, 0);
    chk(draw_done == 1'b0, "R9 done cleared", draw_done, 0);
  endtask

  task automatic t_idle();
    int bad = 0;
    for (int i = 0; i < 20; i++) begin @(negedge clk); if (fb_we) bad++; end
    chk(bad == 0, "R2 no write while solver busy", bad, 0);
  endtask

  // full drawing; pulse=1 drops solve_done after one cycle
  task automatic t_draw(input int seed, input bit pulse);
    int writes = 0, order_bad = 0, col_bad = 0, xr_bad = 0;
    fill(seed);
    solve_done = 1'b1;
    @(negedge clk);
    if (pulse) solve_done = 1'b0;
    chk(fb_we == 1'b0, "R3 no write one cycle after start", fb_we, 0);
    for (int r = 0; r < MH; r++)
      for (int sy = 0; sy < 2; sy++)
        for (int c = 0; c < MW; c++)
          for (int sx = 0; sx < 2; sx++) begin
            @(negedge clk);
            if (fb_we) writes++;
            else chk(0, "R3 gapless write", fb_we, 1);
            if (int'(fb_x) != XO + 2*c + sx || int'(fb_y) != YO + 2*r + sy) begin
              order_bad++;
              if (order_bad == 1) chk(0, "R4 R5 coordinate", int'(fb_x)*1000 + int'(fb_y),
                                      (XO + 2*c + sx)*1000 + YO + 2*r + sy);
            end
            if (fb_color != mem[r*MW + c]) begin
              col_bad++;
              if (col_bad == 1) chk(0, "R6 colour", fb_color, mem[r*MW + c]);
            end
            if (int'(fb_x) >= SW/2) xr_bad++;
          end
    chk(order_bad == 0, "R4 traversal order", order_bad, 0);
    chk(col_bad == 0, "R6 colour alignment", col_bad, 0);
    chk(xr_bad == 0, "R10 left half", xr_bad, 0);
    chk(writes == 4*MW*MH, "R7 write count", writes, 4*MW*MH);
    @(negedge clk);
    chk(fb_we == 1'b0, "R7 no extra write", fb_we, 0);
    chk(draw_done == 1'b1, "R8 done after last write", draw_done, 1);
    solve_done = 1'b1;
    begin
      int bad = 0;
      for (int i = 0; i < 12; i++) begin @(negedge clk); if (fb_we || !draw_done) bad++; end
      chk(bad == 0, "R8 idle and done held", bad, 0);
    end
    solve_done = 1'b0;
  endtask

  task automatic t_abort();
    fill(9);
    solve_done = 1'b1;
    repeat (12) @(negedge clk);
    chk(fb_we == 1'b1, "R9 drawing in progress", fb_we, 1);
    rst_n = 1'b0; solve_done = 1'b0;
    @(negedge clk);
    chk(fb_we == 1'b0, "R9 writes stop on reset", fb_we, 0);
    chk(draw_done == 1'b0, "R9 done low on reset", draw_done, 0);
    rst_n = 1'b1;
    @(negedge clk);
    t_idle();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    fill(0);
    do_reset();
    t_idle();
    t_draw(1, 1'b0);
    do_reset();
    t_draw(2, 1'b1);
    do_reset();
    t_abort();
    t_draw(3, 1'b1);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule